// File: doc/BRIEF.md
# Escalating Per-Core Watchdog

This block holds one watchdog timer for each processor core. Software sets each core's timer by writing a configuration word that holds a 16-bit length and a 2-bit mode. The length is loaded into the top of a down-counter whose low bits start at zero. The counter steps down once per prescaler wrap. If a period passes with no poke, the core's stage moves up one step. The first expiry raises an interrupt request. The second raises a non-maskable interrupt. The third sends a one-cycle chip-wide soft reset request.

Software keeps a core alive by writing that core's poke register. Any poke reloads the period and drops the core back to idle. A register read returns the core's mode, length and current stage. The cores run independently and are selected by an index on the write and read ports.

With the default parameters the counter is 24 bits wide (16 length bits over 8 zero bits) and steps once every 256 clocks. In general one period is length << (LOW_W + PRE_W) clocks.

Top module: `esc_wdog_top`

## Requirements
- R1: After a configuration write or a poke to a core, with mode not 0 and length L not 0, that core's irq output rises exactly T = L << (LOW_W+PRE_W) clock edges after the write edge, and stays low before that.
- R2: In mode 3 the NMI output rises 2T edges after the reload. A soft reset request is sent 3T edges after the reload. The NMI only rises while the irq is already high, and the reset only while the NMI is high.
- R3: The soft reset request is high for exactly one cycle. After it, irq and NMI stay high, no further reset request is sent, and counting stops.
- R4: In mode 1 the core stops at the interrupt stage: the NMI and reset request stay low. In mode 2 it stops at the NMI stage: the reset request stays low.
- R5: After reset, and after any configuration write with mode 0 (bits [1:0] = 0), the core's irq, NMI and reset request are low from the next edge onward. The read-back stage is then 0.
- R6: A write with wr_poke = 1 to a core, whatever the data, clears its irq and NMI at the next edge. It also restarts a full period T, as in R1.
- R7: The read data is registered and follows rd_core with one cycle of latency. Its fields are mode in bits [1:0], stage in bits [3:2] and length in bits [19:4]. The stage field reads 0 when idle, 1 after the interrupt, 2 after the NMI and 3 after the reset request, so bit 3 of the word is set once the NMI stage is reached.
- R8: A write or poke addressed to one core does not change the outputs or the timing of any other core.
- R9: A length of 0 is treated as no timeout: the core never expires, whatever its mode.
- R10: irq and NMI are held levels. Once high, they stay high until a write to that core, and NMI high always implies irq high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_poke | input | 1 | 1 selects the poke register, 0 the configuration register |
| wr_core | input | CORE_W | Core index of the write |
| wr_data | input | DATA_W | Write data (configuration fields; ignored for a poke) |
| rd_core | input | CORE_W | Core index to read back |
| rd_data | output | DATA_W | Registered configuration and stage of the selected core |
| irq_o | output | NUM_CORES | Interrupt request level, one bit per core |
| nmi_o | output | NUM_CORES | Non-maskable interrupt level, one bit per core |
| srst_o | output | NUM_CORES | One-cycle soft reset request, one bit per core |

## Verification
The bench sweeps every mode from 1 to 3 against lengths 1 to 3 on a small prescaler. It checks each output and the read-back stage cycle by cycle against a computed stage, min(k/T, mode). A design off by one prescale step would raise the irq a cycle early or late. One that ignored the mode would escalate past its stop stage. Pokes issued during the interrupt stage and the NMI stage must restart a full period: a design that did not reload the counter would expire too soon. A mode-0 write taken mid-escalation must silence the core, and a zero length must never fire. A poke to a neighbouring core during a live count exposes any decode that shares state between cores.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRQ  = 2'd1,
    ST_NMI  = 2'd2,
    ST_RST  = 2'd3
  } wd_stage_e;

  // configuration word layout, shared by write decode and read-back
  localparam int MODE_LSB  = 0;
  localparam int MODE_W    = 2;
  localparam int STAGE_LSB = 2;
  localparam int STAGE_W   = 2;
  localparam int LEN_LSB   = 4;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  generate
    if (PRE_W == 0) begin : g_direct
      assign tick = run;
    end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || clr) pre_q <= '0;
        else if (run)   pre_q <= pre_q + 1'b1;
      end
      assign tick = run && (&pre_q);
    end
  endgenerate
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             poke_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             irq,
  output logic             nmi,
  output logic             srst,
  output wd_stage_e        stage,
  output logic [MODE_W-1:0] mode_q,
  output logic [LEN_W-1:0] len_q
);
  localparam int CNT_W = LEN_W + LOW_W;

  logic [CNT_W-1:0] cnt_q;
  logic             run, tick, reload;

  // counting only while enabled, length legal and below the mode's stop stage
  assign run    = (mode_q != '0) && (len_q != '0) && (2'(stage) < mode_q);
  assign reload = cfg_we || poke_we;

  wdog_tick #(.PRE_W(PRE_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (reload),
    .run  (run),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      stage  <= ST_IDLE;
      irq    <= 1'b0;
      nmi    <= 1'b0;
      srst   <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
      len_q  <= cfg_len;
      cnt_q  <= CNT_W'(cfg_len) << LOW_W;
      stage  <= ST_IDLE;
      irq    <= 1'b0;
      nmi    <= 1'b0;
      srst   <= 1'b0;
    end else if (poke_we) begin
      cnt_q  <= CNT_W'(len_q) << LOW_W;
      stage  <= ST_IDLE;
      irq    <= 1'b0;
      nmi    <= 1'b0;
      srst   <= 1'b0;
    end else begin
      srst <= 1'b0;
      if (tick) begin
        if (cnt_q == CNT_W'(1)) begin
          cnt_q <= CNT_W'(len_q) << LOW_W;
          stage <= wd_stage_e'(2'(stage) + 2'd1);
          irq   <= 1'b1;
          nmi   <= (stage != ST_IDLE);
          srst  <= (stage == ST_NMI);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CORE_W    = 1,
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic                                wr_poke,
  input  logic [CORE_W-1:0]                   wr_core,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic [CORE_W-1:0]                   rd_core,
  input  logic [NUM_CORES-1:0][STAGE_W-1:0]   stage_all,
  input  logic [NUM_CORES-1:0][MODE_W-1:0]    mode_all,
  input  logic [NUM_CORES-1:0][LEN_W-1:0]     len_all,
  output logic [NUM_CORES-1:0]                cfg_we,
  output logic [NUM_CORES-1:0]                poke_we,
  output logic [MODE_W-1:0]                   cfg_mode,
  output logic [LEN_W-1:0]                    cfg_len,
  output logic [DATA_W-1:0]                   rd_data
);
  assign cfg_mode = wr_data[MODE_LSB +: MODE_W];
  assign cfg_len  = wr_data[LEN_LSB +: LEN_W];

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
      assign cfg_we[c]  = wr_en && !wr_poke && (wr_core == CORE_W'(c));
      assign poke_we[c] = wr_en &&  wr_poke && (wr_core == CORE_W'(c));
    end
  endgenerate

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (rd_core == CORE_W'(c)) begin
        rd_word[MODE_LSB  +: MODE_W]  = mode_all[c];
        rd_word[STAGE_LSB +: STAGE_W] = stage_all[c];
        rd_word[LEN_LSB   +: LEN_W]   = len_all[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end
endmodule

// File: rtl/esc_wdog_top.sv
module esc_wdog_top
  import wdog_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LEN_W     = 16,
  parameter int LOW_W     = 8,
  parameter int PRE_W     = 8,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_poke,
  input  logic [CORE_W-1:0]    wr_core,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [CORE_W-1:0]    rd_core,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] nmi_o,
  output logic [NUM_CORES-1:0] srst_o
);
  logic [NUM_CORES-1:0]               cfg_we, poke_we;
  logic [MODE_W-1:0]                  cfg_mode;
  logic [LEN_W-1:0]                   cfg_len;
  logic [NUM_CORES-1:0][STAGE_W-1:0]  stage_all;
  logic [NUM_CORES-1:0][MODE_W-1:0]   mode_all;
  logic [NUM_CORES-1:0][LEN_W-1:0]    len_all;

  wdog_regif #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W),
    .LEN_W     (LEN_W),
    .DATA_W    (DATA_W)
  ) u_regif (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_poke   (wr_poke),
    .wr_core   (wr_core),
    .wr_data   (wr_data),
    .rd_core   (rd_core),
    .stage_all (stage_all),
    .mode_all  (mode_all),
    .len_all   (len_all),
    .cfg_we    (cfg_we),
    .poke_we   (poke_we),
    .cfg_mode  (cfg_mode),
    .cfg_len   (cfg_len),
    .rd_data   (rd_data)
  );

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      wd_stage_e st;
      wdog_core #(
        .LEN_W (LEN_W),
        .LOW_W (LOW_W),
        .PRE_W (PRE_W)
      ) u_core (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we[c]),
        .poke_we  (poke_we[c]),
        .cfg_mode (cfg_mode),
        .cfg_len  (cfg_len),
        .irq      (irq_o[c]),
        .nmi      (nmi_o[c]),
        .srst     (srst_o[c]),
        .stage    (st),
        .mode_q   (mode_all[c]),
        .len_q    (len_all[c])
      );
      assign stage_all[c] = 2'(st);
    end
  endgenerate
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 wr_poke,
  input logic [CORE_W-1:0]    wr_core,
  input logic [DATA_W-1:0]    wr_data,
  input logic [NUM_CORES-1:0] irq_o,
  input logic [NUM_CORES-1:0] nmi_o,
  input logic [NUM_CORES-1:0] srst_o
);
  generate
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
      logic hit;
      assign hit = wr_en && (wr_core == CORE_W'(i));

      p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        srst_o[i] |=> !srst_o[i]);

      p_rst_after_nmi_r2: assert property (@(posedge clk) disable iff (rst)
        srst_o[i] |-> (nmi_o[i] && $past(nmi_o[i])));

      p_nmi_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_o[i]) |-> $past(irq_o[i]));

      p_nmi_has_irq_r10: assert property (@(posedge clk) disable iff (rst)
        nmi_o[i] |-> irq_o[i]);

      p_irq_held_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_o[i] && !hit) |=> irq_o[i]);

      p_poke_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_poke) |=> (!irq_o[i] && !nmi_o[i] && !srst_o[i]));

      p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && !wr_poke && (wr_data[1:0] == 2'd0)) |=>
          (!irq_o[i] && !nmi_o[i] && !srst_o[i]));
    end
  endgenerate
endmodule

bind esc_wdog_top wdog_checker #(
  .NUM_CORES (NUM_CORES),
  .CORE_W    (CORE_W),
  .DATA_W    (DATA_W)
) u_wdog_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_poke (wr_poke),
  .wr_core (wr_core),
  .wr_data (wr_data),
  .irq_o   (irq_o),
  .nmi_o   (nmi_o),
  .srst_o  (srst_o)
);

// File: tb/tb_esc_wdog_top.sv
module tb_esc_wdog_top;
  localparam int NC     = 2;
  localparam int LEN_W  = 16;
  localparam int LOW_W  = 2;
  localparam int PRE_W  = 2;
  localparam int DATA_W = 32;
  localparam int CW     = 1;
  localparam int SHIFT  = LOW_W + PRE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              wr_poke = 1'b0;
  logic [CW-1:0]     wr_core = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CW-1:0]     rd_core = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NC-1:0]     irq_o, nmi_o, srst_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  esc_wdog_top #(
    .NUM_CORES (NC), .LEN_W (LEN_W), .LOW_W (LOW_W),
    .PRE_W (PRE_W), .DATA_W (DATA_W), .CORE_W (CW)
  ) dut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_poke (wr_poke),
    .wr_core (wr_core), .wr_data (wr_data), .rd_core (rd_core),
    .rd_data (rd_data), .irq_o (irq_o), .nmi_o (nmi_o), .srst_o (srst_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input int core, input int mode, input int len);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_poke = 1'b0;
    wr_core = CW'(core);
    wr_data = DATA_W'((len << 4) | mode);
    rd_core = CW'(core);
    @(posedge clk);
  endtask

  task automatic poke_write(input int core);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_poke = 1'b1;
    wr_core = CW'(core);
    wr_data = 32'hFFFF_FFFF;
    rd_core = CW'(core);
    @(posedge clk);
  endtask

  function automatic int stage_at(input int k, input int mode, input int len);
    int t;
    int s;
    if (mode == 0 || len == 0) return 0;
    t = len << SHIFT;
    s = k / t;
    return (s > mode) ? mode : s;
  endfunction

  // Runs n cycles from the load edge (k = 0) and checks one core.
  // poke_at >= 0 pokes the other core at that cycle; other_quiet checks it stays low.
  task automatic run(input int core, input int mode, input int len, input int n,
                     input string tag, input int poke_at, input bit other_quiet);
    int other;
    other = 1 - core;
    for (int k = 0; k <= n; k++) begin
      int s;
      int exp_v;
      int act_v;
      string tg;
      @(negedge clk);
      if (k == 0) wr_en = 1'b0;
      if (poke_at >= 0 && k == poke_at) begin
        wr_en = 1'b1; wr_poke = 1'b1; wr_core = CW'(other);
      end else if (poke_at >= 0 && k == poke_at + 1) begin
        wr_en = 1'b0;
      end
      s = stage_at(k, mode, len);
      exp_v = {(s >= 1), (s >= 2), (mode == 3 && len != 0 && k == 3 * (len << SHIFT))};
      act_v = {irq_o[core], nmi_o[core], srst_o[core]};
      if (tag != "") tg = tag;
      else if (k <= (len << SHIFT)) tg = "R1";
      else if (mode < 3) tg = "R4";
      else if (k < 3 * (len << SHIFT)) tg = "R2";
      else tg = "R3";
      chk(act_v == exp_v, tg, act_v, exp_v);
      if (k >= 1) begin
        int es;
        es = stage_at(k - 1, mode, len);
        chk(int'(rd_data[3:2]) == es, "R7 stage", int'(rd_data[3:2]), es);
      end
      if (k == 1) begin
        chk(int'(rd_data[1:0]) == mode, "R7 mode", int'(rd_data[1:0]), mode);
        chk(int'(rd_data[19:4]) == len, "R7 length", int'(rd_data[19:4]), len);
      end
      if (k == n) chk(act_v == exp_v, "R10 held level", act_v, exp_v);
      if (other_quiet)
        chk({irq_o[other], nmi_o[other], srst_o[other]} == 3'b000, "R8 other core",
            int'({irq_o[other], nmi_o[other], srst_o[other]}), 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: reset state
    chk({irq_o, nmi_o, srst_o} == '0, "R5 reset outputs", int'({irq_o, nmi_o, srst_o}), 0);
    chk(rd_data == '0, "R5 reset readback", int'(rd_data), 0);

    // R1 R2 R3 R4 R7: sweep of modes and lengths
    for (int m = 1; m <= 3; m++)
      for (int l = 1; l <= 3; l++) begin
        cfg_write(0, m, l);
        run(0, m, l, 3 * (l << SHIFT) + 6, "", -1, 1'b0);
      end

    // R6: poke during interrupt stage restarts a full period
    cfg_write(0, 3, 2);
    run(0, 3, 2, 40, "R6", -1, 1'b0);
    poke_write(0);
    run(0, 3, 2, 3 * (2 << SHIFT) + 6, "R6", -1, 1'b0);

    // R6: poke during NMI stage in mode 2
    cfg_write(0, 2, 1);
    run(0, 2, 1, 40, "R6", -1, 1'b0);
    poke_write(0);
    run(0, 2, 1, 40, "R6", -1, 1'b0);

    // R5: mode-0 write mid escalation
    cfg_write(0, 3, 1);
    run(0, 3, 1, 40, "R5", -1, 1'b0);
    cfg_write(0, 0, 0);
    run(0, 0, 0, 60, "R5", -1, 1'b0);

    // R9: zero length never fires
    cfg_write(0, 3, 0);
    run(0, 3, 0, 100, "R9", -1, 1'b0);

    // R8: poke to core 1 leaves core 0 timing unchanged
    cfg_write(1, 3, 3);
    cfg_write(0, 3, 1);
    run(0, 3, 1, 3 * (1 << SHIFT) + 4, "R8", 8, 1'b1);

    // R8: core 1 escalates alone while core 0 is off
    cfg_write(0, 0, 0);
    cfg_write(1, 3, 1);
    run(1, 3, 1, 3 * (1 << SHIFT) + 6, "R8", -1, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule